// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers a set of interrupt sources and decides which one, if any, is presented to the processor. Every source owns a cause flag, an enable bit and a 3-bit priority level. A source event sets its cause flag whether or not the source is enabled. Software clears a flag by writing 1 to its bit. A source is pending when its flag and its enable are both 1.

Among the pending sources, the one with the highest level wins. Equal levels go to the lower source index. The winner's index and level are registered. A combinational acceptance output then compares the winning level against the processor's global interrupt-enable bit and its current interrupt level. A request is accepted only when interrupts are enabled and the current level is strictly lower than the winning level.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A pulse on `evt_i[i]` sets cause flag i at that clock edge, whether enable i is 0 or 1. A flag that was latched while disabled produces a request once the enable is later set.
- R2: Source i is pending only when cause flag i and enable i are both 1. With no source pending, `req_valid` is 0.
- R3: Each source has a 3-bit level. It is written with `prio_we`=1, the source number on `prio_sel` and the level on `prio_wdata`. `req_lvl` reports the winner's level.
- R4: `req_idx` names a pending source whose level is greater than or equal to that of every other pending source.
- R5: When several pending sources share the highest level, the lowest index among them wins.
- R6: With `flag_clr_we`=1, each 1 bit of `flag_clr_mask` clears that cause flag at the edge. If an event for the same source arrives in the same cycle, the flag stays set.
- R7: `req_accept` equals `req_valid` AND `cpu_ie` AND (`cpu_il` < `req_lvl`), with the comparison unsigned. A winner of level 0 is therefore never accepted.
- R8: `req_valid`, `req_idx` and `req_lvl` are registered. They reflect the flags, enables and levels held after the previous edge. A request therefore appears on the second edge after an event pulse, and it drops on the edge after the edge that clears its flag or removes its enable.
- R9: After reset, all flags, enables and levels are 0, and `req_valid`, `req_idx`, `req_lvl` and `req_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Per-source event pulses |
| flag_clr_we | input | 1 | Strobe for write-1-to-clear of the cause flags |
| flag_clr_mask | input | NUM_SRC | Flags to clear when the strobe is high |
| en_we | input | 1 | Strobe for writing the enable vector |
| en_wdata | input | NUM_SRC | New enable vector |
| prio_we | input | 1 | Strobe for writing one source's level |
| prio_sel | input | IDX_W | Source number for the level write |
| prio_wdata | input | 3 | Level value |
| cpu_ie | input | 1 | Processor global interrupt enable |
| cpu_il | input | 3 | Processor current interrupt level |
| req_valid | output | 1 | A pending enabled request exists |
| req_idx | output | IDX_W | Winning source index |
| req_lvl | output | 3 | Winning level |
| req_accept | output | 1 | The processor takes the request |

## Verification
The bench builds the default configuration: eight sources with 3-bit levels. At that size every single source can be swept through every level. For each level the bench also tries all sixteen combinations of processor enable and current level, which covers the strict-less-than boundary and the level-0 case completely. Every ordered pair of distinct sources is then tried with all 64 level combinations, so every tie and every inversion of index order against level order is reached. Dedicated sequences cover these cases:
- a flag latched while its source is disabled;
- a clear that collides with an event in the same cycle;
- the edge-by-edge timing of a request appearing and dropping.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // Processor-side acceptance test: global enable and strict level compare.
  function automatic logic cpu_takes(input logic valid, input logic ie,
                                     input lvl_t cur, input lvl_t win);
    return valid && ie && (cur < win);
  endfunction

  // Next state of one cause flag: an event beats a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic clr,
                                     input logic evt);
    return (cur && !clr) || evt;
  endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            evt_i,
  input  logic                          flag_clr_we,
  input  logic [NUM_SRC-1:0]            flag_clr_mask,
  input  logic                          en_we,
  input  logic [NUM_SRC-1:0]            en_wdata,
  input  logic                          prio_we,
  input  logic [IDX_W-1:0]              prio_sel,
  input  logic [LVL_W-1:0]              prio_wdata,
  output logic [NUM_SRC-1:0]            flag_q,
  output logic [NUM_SRC-1:0]            en_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0] prio_q
);

  logic [NUM_SRC-1:0] clr_hit;
  assign clr_hit = flag_clr_we ? flag_clr_mask : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        prio_q[i] <= '0;
      end else begin
        flag_q[i] <= flag_next(flag_q[i], clr_hit[i], evt_i[i]);
        if (prio_we && (prio_sel == IDX_W'(i))) prio_q[i] <= prio_wdata;
      end
    end

    // R1: event sets the flag regardless of enable
    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_q[i]);
    // R6: a clear without a colliding event empties the flag
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !evt_i[i]) |=> !flag_q[i]);
    // R6: without event or clear a flag holds its value
    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_hit[i] && !evt_i[i]) |=> $stable(flag_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

endmodule

// File: rtl/irq_winner_pick.sv
module irq_winner_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
  output logic                          win_any,
  output logic [IDX_W-1:0]              win_idx,
  output logic [LVL_W-1:0]              win_lvl
);

  // Ascending scan, replacing only on a strictly higher level: ties keep the lower index.
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!win_any || (prio[i] > win_lvl))) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = prio[i];
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R4: no pending source outranks the chosen one
    assert_winner_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |-> (win_any && (win_lvl >= prio[i])));
    // R5: on equal level the chosen index is not above any tied source
    assert_tie_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && (prio[i] == win_lvl)) |-> (win_idx <= IDX_W'(i)));
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               flag_clr_we,
  input  logic [NUM_SRC-1:0] flag_clr_mask,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               prio_we,
  input  logic [IDX_W-1:0]   prio_sel,
  input  logic [LVL_W-1:0]   prio_wdata,
  input  logic               cpu_ie,
  input  logic [LVL_W-1:0]   cpu_il,
  output logic               req_valid,
  output logic [IDX_W-1:0]   req_idx,
  output logic [LVL_W-1:0]   req_lvl,
  output logic               req_accept
);

  logic [NUM_SRC-1:0]            flag_q;
  logic [NUM_SRC-1:0]            en_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] prio_q;
  logic [NUM_SRC-1:0]            pend;
  logic                          win_any;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;

  irq_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .en_we(en_we), .en_wdata(en_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q)
  );

  assign pend = flag_q & en_q;

  irq_winner_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend), .prio(prio_q),
    .win_any(win_any), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_idx   <= '0;
      req_lvl   <= '0;
    end else begin
      req_valid <= win_any;
      req_idx   <= win_idx;
      req_lvl   <= win_lvl;
    end
  end

  assign req_accept = cpu_takes(req_valid, cpu_ie, cpu_il, req_lvl);

  // R2: a registered request traces back to a pending source one cycle earlier
  assert_req_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(|pend));
  // R8: with nothing pending, the request is gone after the next edge
  assert_req_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> !req_valid);
  // R7: a level-0 winner is never taken
  assert_lvl0_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (req_lvl != '0));
  // R7: acceptance needs a live request and the global enable
  assert_accept_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (req_valid && cpu_ie));

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         flag_clr_we = 1'b0;
  logic [N-1:0] flag_clr_mask = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         prio_we = 1'b0;
  logic [2:0]   prio_sel = '0;
  logic [2:0]   prio_wdata = '0;
  logic         cpu_ie = 1'b0;
  logic [2:0]   cpu_il = '0;
  logic         req_valid;
  logic [2:0]   req_idx;
  logic [2:0]   req_lvl;
  logic         req_accept;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .en_we(en_we), .en_wdata(en_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .cpu_ie(cpu_ie), .cpu_il(cpu_il),
    .req_valid(req_valid), .req_idx(req_idx), .req_lvl(req_lvl),
    .req_accept(req_accept)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_flag = '0;
  logic [N-1:0] m_en = '0;
  int           m_prio [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] ev, input logic [N-1:0] clr,
                      input bit do_en, input logic [N-1:0] env,
                      input bit do_pr, input int sel, input int pv);
    evt_i = ev; flag_clr_we = |clr; flag_clr_mask = clr;
    en_we = do_en; en_wdata = env;
    prio_we = do_pr; prio_sel = 3'(sel); prio_wdata = 3'(pv);
    @(posedge clk); #1;
    evt_i = '0; flag_clr_we = 1'b0; flag_clr_mask = '0;
    en_we = 1'b0; prio_we = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (clr[i]) m_flag[i] = 1'b0;
      if (ev[i]) m_flag[i] = 1'b1;
    end
    if (do_en) m_en = env;
    if (do_pr) m_prio[sel] = pv;
  endtask

  task automatic idle();
    step('0, '0, 1'b0, '0, 1'b0, 0, 0);
  endtask

  // Independent model: descending scan taking any level >= the best so far.
  task automatic check_out(input string tag);
    bit ev = 0; int ei = 0; int el = 0; bit ea;
    for (int i = N - 1; i >= 0; i--)
      if (m_flag[i] && m_en[i] && (!ev || m_prio[i] >= el)) begin
        ev = 1; ei = i; el = m_prio[i];
      end
    ea = ev && cpu_ie && (int'(cpu_il) < el);
    chk(req_valid == ev, {tag, " valid"}, req_valid, ev);
    if (ev) begin
      chk(int'(req_idx) == ei, {tag, " idx"}, req_idx, ei);
      chk(int'(req_lvl) == el, {tag, " lvl"}, req_lvl, el);
    end
    chk(req_accept == ea, {tag, " accept"}, req_accept, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state
    chk(req_valid == 0, "R9 reset valid", req_valid, 0);
    chk(req_idx == 0, "R9 reset idx", req_idx, 0);
    chk(req_lvl == 0, "R9 reset lvl", req_lvl, 0);
    cpu_ie = 1'b1;
    #1 chk(req_accept == 0, "R9 reset accept", req_accept, 0);
    idle();

    // R3 / R7: one source at every level, every processor enable and level
    for (int s = 0; s < N; s++)
      for (int l = 0; l < 8; l++) begin
        step('0, '1, 1'b1, N'(1) << s, 1'b1, s, l);
        step(N'(1) << s, '0, 1'b0, '0, 1'b0, 0, 0);
        idle();
        for (int ie = 0; ie < 2; ie++)
          for (int il = 0; il < 8; il++) begin
            cpu_ie = ie[0]; cpu_il = 3'(il);
            #1 check_out("R3 R7 single");
          end
      end

    // R1 / R2: flag latched while disabled
    for (int s = 0; s < N; s++) begin
      step('0, '1, 1'b1, '0, 1'b1, s, 5);
      step(N'(1) << s, '0, 1'b0, '0, 1'b0, 0, 0);
      idle();
      chk(req_valid == 0, "R2 disabled source no request", req_valid, 0);
      step('0, '0, 1'b1, N'(1) << s, 1'b0, 0, 0);
      idle();
      chk(req_valid == 1, "R1 flag kept while disabled", req_valid, 1);
      check_out("R1 latched");
    end

    // R4 / R5: every ordered pair at every level combination
    cpu_ie = 1'b1; cpu_il = 3'd2;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (a != b)
          for (int la = 0; la < 8; la++)
            for (int lb = 0; lb < 8; lb++) begin
              step('0, '1, 1'b1, (N'(1) << a) | (N'(1) << b), 1'b1, a, la);
              step((N'(1) << a) | (N'(1) << b), '0, 1'b0, '0, 1'b1, b, lb);
              idle();
              check_out("R4 R5 pair");
            end

    // R6 / R8: clear colliding with an event, then clear alone, edge by edge
    step('0, '1, 1'b1, 8'h10, 1'b1, 4, 6);
    step(8'h10, '0, 1'b0, '0, 1'b0, 0, 0);
    chk(req_valid == 0, "R8 not yet valid one edge after event", req_valid, 0);
    idle();
    chk(req_valid == 1, "R8 valid two edges after event", req_valid, 1);
    step(8'h10, 8'h10, 1'b0, '0, 1'b0, 0, 0);
    idle();
    chk(req_valid == 1, "R6 event beats clear", req_valid, 1);
    step('0, 8'h10, 1'b0, '0, 1'b0, 0, 0);
    chk(req_valid == 1, "R8 still valid on clear edge", req_valid, 1);
    idle();
    chk(req_valid == 0, "R6 R8 dropped after clear", req_valid, 0);
    step(8'h10, '0, 1'b0, '0, 1'b0, 0, 0);
    idle();
    step('0, '0, 1'b1, '0, 1'b0, 0, 0);
    chk(req_valid == 1, "R8 still valid on disable edge", req_valid, 1);
    idle();
    chk(req_valid == 0, "R2 R8 dropped after disable", req_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule